// File: doc/BRIEF.md
# Receive Channel Router and Word Interleaver

This block sits between four 12-bit sample converters and a host-bound FIFO. Each of four downconversion channels takes its I input and its Q input from any converter, chosen on its own, so several channels can share one converter stream. The downconverters are modelled as pass-through, so a routed sample goes straight to a sign-extension stage that widens it to a 16-bit signed word.

On each pulse of a common sample strobe, the block captures a complete frame of 2N words for the N active channels. It then hands the frame out one word per accepted handshake in a fixed order: I0, Q0, I1, Q1, up to channel N-1. A new frame then starts again from I0. A single routing register, 16 bits wide, holds the per-slot source indices. It can be written at any time, but a new value is used only from the next captured frame. If a strobe arrives while a frame is still draining, the new frame is dropped and a sticky overrun flag is raised.

The sequencer has two states. `S_IDLE` holds no frame. `S_SEND` presents words. The transitions are: capture (`S_IDLE` to `S_SEND` on a strobe), advance (`S_SEND` to `S_SEND` on an accepted word that is not the last), drain (`S_SEND` to `S_IDLE` when the last word is accepted and no strobe arrives), restart (`S_SEND` to `S_SEND` when the last word is accepted in the same cycle as a strobe) and drop (a strobe in `S_SEND` without the last word being accepted; the state is unchanged and the overrun flag is set).

Top module: `rx_route_ilv`

## Requirements
- R1: Converter c drives `conv_data[12c+11:12c]`. Word slot j (I of channel k is j=2k, Q of channel k is j=2k+1) takes its sample from the converter whose index is in `cfg_wdata[2j+1:2j]`. Any converter may feed any number of slots.
- R2: Each output word is the 12-bit two's-complement sample sign-extended to 16 bits. For example, 12'h800 becomes 16'hF800 and 12'h7FF becomes 16'h07FF.
- R3: After a capture, the block presents exactly 2N words in the order slot 0, 1, ..., 2N-1, and then deasserts `out_valid`.
- R4: When `num_chan` is 1, 2 or 4, that is the number of active channels N. Any other value gives N=1. The value is sampled at capture.
- R5: A write to the routing register leaves the frame already captured unchanged. A write in the same cycle as a capture is not used by that frame. The next capture uses the new value.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: A strobe that arrives while a frame is presented, other than in the cycle its last word is accepted, is discarded. The current frame continues unchanged, and `overrun` rises in the next cycle and stays high until reset.
- R8: A strobe in the same cycle as the last word of a frame is accepted captures a new frame. That frame's slot 0 is presented in the next cycle, and `overrun` does not rise.
- R9: Reset clears `out_valid` and `overrun`. It also loads the routing register with 16'hFA50, so both I and Q of channel k come from converter k.
- R10: A strobe in `S_IDLE` makes `out_valid` high with slot 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_data | input | 48 | Four packed 12-bit converter samples |
| sample_stb | input | 1 | Common sample strobe; captures a frame |
| num_chan | input | 3 | Requested active channel count |
| cfg_we | input | 1 | Routing register write enable |
| cfg_wdata | input | 16 | Routing register write value, 2 bits per slot |
| out_data | output | 16 | Sign-extended output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| overrun | output | 1 | Sticky dropped-frame flag |

## Verification
Two events can fall in the same cycle: acceptance of a frame's last word and the arrival of a new strobe. The bench provokes this by raising the strobe exactly when the final word of a one-channel frame is on the output with ready high. It judges the outcome by whether the new frame's first word appears in the next cycle with `overrun` still low. A second coincidence, a routing write landing on a capture edge, is judged by checking that the frame just captured uses the old routing and the following frame uses the new one.

// File: rtl/rx_route_pkg.sv
package rx_route_pkg;
    localparam int unsigned RR_NCONV = 4;
    localparam int unsigned RR_NCH   = 4;
    localparam int unsigned RR_SW    = 12;
    localparam int unsigned RR_OW    = 16;
    localparam int unsigned RR_CNTW  = 3;
    localparam int unsigned RR_SELW  = $clog2(RR_NCONV);
    localparam int unsigned RR_NSLOT = 2 * RR_NCH;
    localparam int unsigned RR_CFGW  = RR_NSLOT * RR_SELW;
    localparam int unsigned RR_IDXW  = $clog2(RR_NSLOT);

    typedef enum logic {
        S_IDLE,
        S_SEND
    } seq_state_t;
endpackage

// File: rtl/rx_route_cfg.sv
module rx_route_cfg
    import rx_route_pkg::*;
#(
    parameter int unsigned NSLOT = RR_NSLOT,
    parameter int unsigned SELW  = RR_SELW,
    localparam int unsigned CFGW = NSLOT * SELW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CFGW-1:0] cfg_wdata,
    output logic [CFGW-1:0] route
);
    // Slot j = 2k (I) or 2k+1 (Q) of channel k defaults to converter k
    function automatic logic [CFGW-1:0] home_route();
        logic [CFGW-1:0] r;
        r = '0;
        for (int j = 0; j < int'(NSLOT); j++) begin
            r[j*SELW +: SELW] = SELW'(j / 2);
        end
        return r;
    endfunction

    localparam logic [CFGW-1:0] ROUTE_RST = home_route();

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route <= ROUTE_RST;
        end else if (cfg_we) begin
            route <= cfg_wdata;
        end
    end

    p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (route == $past(cfg_wdata)));
endmodule

// File: rtl/rx_route_mux.sv
module rx_route_mux
    import rx_route_pkg::*;
#(
    parameter int unsigned NCONV = RR_NCONV,
    parameter int unsigned NSLOT = RR_NSLOT,
    parameter int unsigned SW    = RR_SW,
    parameter int unsigned OW    = RR_OW,
    localparam int unsigned SELW = $clog2(NCONV),
    localparam int unsigned CFGW = NSLOT * SELW
) (
    input  logic [NCONV*SW-1:0] conv_data,
    input  logic [CFGW-1:0]     route,
    output logic [NSLOT*OW-1:0] words
);
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        logic [SELW-1:0] sel;
        logic [SW-1:0]   samp;
        always_comb begin
            sel  = route[j*SELW +: SELW];
            samp = conv_data[sel*SW +: SW];
            words[j*OW +: OW] = {{(OW-SW){samp[SW-1]}}, samp};
        end
    end
endmodule

// File: rtl/rx_route_seq.sv
module rx_route_seq
    import rx_route_pkg::*;
#(
    parameter int unsigned NSLOT = RR_NSLOT,
    parameter int unsigned OW    = RR_OW,
    parameter int unsigned CNTW  = RR_CNTW,
    localparam int unsigned IDXW = $clog2(NSLOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [CNTW-1:0]    num_chan,
    input  logic [NSLOT*OW-1:0] words,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [OW-1:0]      out_data,
    output logic               overrun
);
    seq_state_t          state, nxt;
    logic [NSLOT*OW-1:0] frame_q;
    logic [IDXW-1:0]     idx, last_q, last_dec;
    logic                accept, last_acc, take, drop;

    // Last slot index for the requested count; unsupported counts mean one channel
    always_comb begin
        unique case (num_chan)
            CNTW'(2): last_dec = IDXW'(3);
            CNTW'(4): last_dec = IDXW'(7);
            default:  last_dec = IDXW'(1);
        endcase
    end

    always_comb begin
        accept   = (state == S_SEND) && out_ready;
        last_acc = accept && (idx == last_q);
        take     = sample_stb && ((state == S_IDLE) || last_acc);
        drop     = sample_stb && (state == S_SEND) && !last_acc;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (sample_stb)              nxt = S_SEND; // capture
            S_SEND: if (last_acc && !sample_stb) nxt = S_IDLE; // drain
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx     <= '0;
            last_q  <= '0;
            overrun <= 1'b0;
        end else begin
            if (take) begin
                frame_q <= words;
                idx     <= '0;
                last_q  <= last_dec;
            end else if (accept) begin
                idx <= idx + 1'b1;
            end
            if (drop) overrun <= 1'b1;
        end
    end

    always_comb begin
        out_valid = (state == S_SEND);
        out_data  = frame_q[idx*OW +: OW];
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sample_stb && !(out_ready && idx == last_q)) |=> overrun);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && idx == last_q && sample_stb) |=> (out_valid && idx == '0));
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && sample_stb) |=> (out_valid && idx == '0));
    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx <= last_q));
endmodule

// File: rtl/rx_route_ilv.sv
module rx_route_ilv
    import rx_route_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RR_NCONV*RR_SW-1:0] conv_data,
    input  logic                   sample_stb,
    input  logic [RR_CNTW-1:0]     num_chan,
    input  logic                   cfg_we,
    input  logic [RR_CFGW-1:0]     cfg_wdata,
    output logic [RR_OW-1:0]       out_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic                   overrun
);
    logic [RR_CFGW-1:0]        route;
    logic [RR_NSLOT*RR_OW-1:0] words;

    rx_route_cfg #(.NSLOT(RR_NSLOT), .SELW(RR_SELW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .route     (route)
    );

    rx_route_mux #(.NCONV(RR_NCONV), .NSLOT(RR_NSLOT), .SW(RR_SW), .OW(RR_OW)) u_mux (
        .conv_data (conv_data),
        .route     (route),
        .words     (words)
    );

    rx_route_seq #(.NSLOT(RR_NSLOT), .OW(RR_OW), .CNTW(RR_CNTW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .num_chan   (num_chan),
        .words      (words),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .overrun    (overrun)
    );
endmodule

// File: tb/sim_rx_route_ilv.sv
module sim_rx_route_ilv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] conv_data = '0;
    logic        sample_stb = 1'b0;
    logic [2:0]  num_chan = 3'd4;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        overrun;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    rx_route_ilv u0 (.*);

    function automatic logic [15:0] pick(input logic [15:0] rt, input logic [47:0] cv, input int j);
        logic [1:0]  s;
        logic [11:0] v;
        s = rt[j*2 +: 2];
        v = cv[s*12 +: 12];
        return {{4{v[11]}}, v};
    endfunction

    function automatic int nwords(input logic [2:0] n);
        if (n == 3'd2) return 4;
        if (n == 3'd4) return 8;
        return 2;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_route(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Pulse the strobe for one cycle; returns at the negedge after capture
    task automatic start_frame(input logic [47:0] cv, input logic [2:0] n);
        @(negedge clk);
        conv_data = cv; num_chan = n; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic drain(input logic [15:0] rt, input logic [47:0] cv, input int nw, input string req);
        out_ready = 1'b1;
        conv_data = ~cv;
        for (int j = 0; j < nw; j++) begin
            chk(out_valid && out_data == pick(rt, cv, j), req, {15'd0, out_valid, out_data}, {15'd0, 1'b1, pick(rt, cv, j)});
            @(negedge clk);
        end
        chk(!out_valid, {req, " end-of-frame"}, {31'd0, out_valid}, 32'd0);
    endtask

    localparam logic [47:0] CV_A = {12'h123, 12'hFFF, 12'h7FF, 12'h800};
    localparam logic [47:0] CV_B = {12'h401, 12'hA5A, 12'h0F0, 12'hC03};

    task automatic t_reset();
        chk(!out_valid, "R9 valid after reset", {31'd0, out_valid}, 32'd0);
        chk(!overrun, "R9 overrun after reset", {31'd0, overrun}, 32'd0);
        start_frame(CV_B, 3'd4);
        drain(16'hFA50, CV_B, 8, "R9 R3 R10 default routing");
    endtask

    task automatic t_route();
        wr_route(16'h39C6);
        start_frame(CV_A, 3'd4);
        drain(16'h39C6, CV_A, 8, "R1 R2 custom routing sign-extension");
        wr_route(16'hAAAA);
        start_frame(CV_A, 3'd4);
        drain(16'hAAAA, CV_A, 8, "R1 shared converter");
    endtask

    task automatic t_count();
        logic [2:0] ns [5] = '{3'd2, 3'd1, 3'd3, 3'd0, 3'd7};
        wr_route(16'h1B4E);
        foreach (ns[i]) begin
            start_frame(CV_B, ns[i]);
            drain(16'h1B4E, CV_B, nwords(ns[i]), $sformatf("R4 count=%0d", ns[i]));
        end
    endtask

    task automatic t_cfg_timing();
        wr_route(16'h0000);
        start_frame(CV_A, 3'd2);
        chk(out_data == pick(16'h0000, CV_A, 0), "R5 slot0 pre-write", {16'd0, out_data}, {16'd0, pick(16'h0000, CV_A, 0)});
        cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        conv_data = ~CV_A;
        for (int j = 1; j < 4; j++) begin
            chk(out_valid && out_data == pick(16'h0000, CV_A, j), "R5 frame unchanged by write", {16'd0, out_data}, {16'd0, pick(16'h0000, CV_A, j)});
            @(negedge clk);
        end
        // write lands on the capture edge: old routing for this frame
        @(negedge clk);
        conv_data = CV_B; num_chan = 3'd1; sample_stb = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h5555;
        @(negedge clk);
        sample_stb = 1'b0; cfg_we = 1'b0;
        drain(16'hFFFF, CV_B, 2, "R5 same-cycle write ignored");
        start_frame(CV_B, 3'd1);
        drain(16'h5555, CV_B, 2, "R5 new routing next frame");
    endtask

    task automatic t_back2back();
        wr_route(16'hE4E4);
        start_frame(CV_A, 3'd1);
        chk(out_data == pick(16'hE4E4, CV_A, 0), "R8 first word", {16'd0, out_data}, {16'd0, pick(16'hE4E4, CV_A, 0)});
        @(negedge clk);
        chk(out_data == pick(16'hE4E4, CV_A, 1), "R8 last word", {16'd0, out_data}, {16'd0, pick(16'hE4E4, CV_A, 1)});
        conv_data = CV_B; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        chk(!overrun, "R8 no overrun on restart", {31'd0, overrun}, 32'd0);
        drain(16'hE4E4, CV_B, 2, "R8 restart frame");
    endtask

    task automatic t_overrun();
        out_ready = 1'b0;
        @(negedge clk);
        conv_data = CV_A; num_chan = 3'd2; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(out_valid && out_data == pick(16'hE4E4, CV_A, 0), "R6 hold under backpressure", {16'd0, out_data}, {16'd0, pick(16'hE4E4, CV_A, 0)});
            @(negedge clk);
        end
        conv_data = CV_B; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        chk(overrun, "R7 overrun raised", {31'd0, overrun}, 32'd1);
        drain(16'hE4E4, CV_A, 4, "R7 old frame continues");
        chk(overrun, "R7 overrun sticky", {31'd0, overrun}, 32'd1);
        do_reset();
        chk(!overrun, "R9 reset clears overrun", {31'd0, overrun}, 32'd0);
        chk(!out_valid, "R9 reset clears valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_route();
        t_count();
        t_cfg_timing();
        t_back2back();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule